// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block is a hardware barrier for a fixed group of participants. A participant pulses its arrive strobe when it reaches a synchronization point and then waits until its release output goes high. The unit counts arrivals for the current episode. When the last participant of the group has arrived, the count returns to zero and the global flag flips. Every participant that was waiting in that episode then sees its release output rise in the same cycle.

Each participant has its own sense bit, and that bit inverts when the participant's arrival is accepted. A participant is released while its sense bit equals the global flag. The flag therefore never needs a separate clearing phase. A participant that leaves one episode and arrives again at once is counted only toward the next episode, so it cannot slip through that episode early. Participants that are still waiting cannot re-arm the barrier, because a strobe from a waiting participant is dropped.

Top module: `sense_barrier`

## Requirements
- R1: While reset is low and in the first cycle after it, the global flag is 0, every participant's sense bit is 0, the arrival count is 0 and every release output is high.
- R2: An arrive strobe from a released participant that does not complete the episode makes that participant's release output low from the next clock edge.
- R3: An arrive strobe from a participant whose release output is low is ignored. The participant stays waiting and is not counted a second time.
- R4: Arrivals from several released participants in the same cycle are all counted in that cycle.
- R5: At the edge where the accepted arrivals of the episode reach the group size, the global flag inverts and every release output is high from that edge.
- R6: A waiting participant's release output only rises at an edge where the global flag inverts. Fewer than the group size of distinct arrivals never releases anyone.
- R7: An arrival accepted in the cycle right after a completion counts toward the next episode only. The flag alternates 0, 1, 0 over successive episodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| arriveStb | input | NUM_PARTS | One arrival pulse per participant, sampled each cycle |
| releaseOut | output | NUM_PARTS | High while the participant's sense equals the global flag |
| globalFlag | output | 1 | Sense published by the last arrival of the most recent episode |

## Verification
The bench targets these corner cases:
- **Repeated strobes.** A participant strobes again while it is waiting. A design that counted the repeat would complete the episode early and free others that had not arrived.
- **All arrive at once.** Every participant arrives in one cycle. A counter that adds only one arrival per cycle would hang the episode forever.
- **Immediate re-arrival.** A participant arrives again in the cycle right after a release. A design that cleared the flag or reused a stale count would either trap that participant or let it through without waiting.
- **Random stress.** Long random strobe patterns are compared every cycle against a bench model of the sense bits, the flag and the count.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic advance;   // at least one arrival accepted this cycle
    logic complete;  // episode finishes at this edge
  } barStrobe_t;
endpackage

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
#(
  parameter int NUM_PARTS = 4,
  localparam int CW = $clog2(NUM_PARTS + 1),
  localparam int SW = CW + 1
) (
  input  logic [NUM_PARTS-1:0] arriveStb,
  input  logic [NUM_PARTS-1:0] localSense,
  input  logic                 flagQ,
  input  logic [CW-1:0]        countQ,
  output logic [NUM_PARTS-1:0] acceptMask,
  output logic [CW-1:0]        nextCount,
  output barStrobe_t           strobes
);
  logic [SW-1:0] popCnt;
  logic [SW-1:0] sumCnt;

  always_comb begin
    // only participants currently released may register an arrival
    acceptMask = arriveStb & ~(localSense ^ {NUM_PARTS{flagQ}});
    popCnt = '0;
    for (int i = 0; i < NUM_PARTS; i++) begin
      popCnt = popCnt + SW'(acceptMask[i]);
    end
    sumCnt = SW'(countQ) + popCnt;
    nextCount = sumCnt[CW-1:0];
    strobes.advance  = |acceptMask;
    strobes.complete = (sumCnt == SW'(NUM_PARTS));
  end
endmodule

// File: rtl/barrier_dp.sv
module barrier_dp
  import barrier_pkg::*;
#(
  parameter int NUM_PARTS = 4,
  localparam int CW = $clog2(NUM_PARTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PARTS-1:0] acceptMask,
  input  logic [CW-1:0]        nextCount,
  input  barStrobe_t           strobes,
  output logic [NUM_PARTS-1:0] localSense,
  output logic                 flagQ,
  output logic [CW-1:0]        countQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      localSense <= '0;
      flagQ      <= 1'b0;
      countQ     <= '0;
    end else begin
      localSense <= localSense ^ acceptMask;
      if (strobes.complete) begin
        countQ <= '0;
        flagQ  <= ~flagQ;
      end else if (strobes.advance) begin
        countQ <= nextCount;
      end
    end
  end
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier
  import barrier_pkg::*;
#(
  parameter int NUM_PARTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PARTS-1:0] arriveStb,
  output logic [NUM_PARTS-1:0] releaseOut,
  output logic                 globalFlag
);
  localparam int CW = $clog2(NUM_PARTS + 1);

  logic [NUM_PARTS-1:0] acceptMask;
  logic [NUM_PARTS-1:0] localSense;
  logic [CW-1:0]        nextCount;
  logic [CW-1:0]        countQ;
  logic                 flagQ;
  barStrobe_t           strobes;

  barrier_ctrl #(.NUM_PARTS(NUM_PARTS)) u_ctrl (
    .arriveStb (arriveStb),
    .localSense(localSense),
    .flagQ     (flagQ),
    .countQ    (countQ),
    .acceptMask(acceptMask),
    .nextCount (nextCount),
    .strobes   (strobes)
  );

  barrier_dp #(.NUM_PARTS(NUM_PARTS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .acceptMask(acceptMask),
    .nextCount (nextCount),
    .strobes   (strobes),
    .localSense(localSense),
    .flagQ     (flagQ),
    .countQ    (countQ)
  );

  assign releaseOut = ~(localSense ^ {NUM_PARTS{flagQ}});
  assign globalFlag = flagQ;
endmodule

// File: rtl/barrier_chk.sv
module barrier_chk #(
  parameter int NUM_PARTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PARTS-1:0] arriveStb,
  input logic [NUM_PARTS-1:0] releaseOut,
  input logic                 globalFlag
);
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rstN) |-> (globalFlag == 1'b0) && (&releaseOut));

  a_r5_flip_releases_all: assert property (@(posedge clk) disable iff (!rstN)
    (globalFlag != $past(globalFlag)) |-> (&releaseOut));

  for (genvar i = 0; i < NUM_PARTS; i++) begin : g_part
    a_r2_arrival_waits: assert property (@(posedge clk) disable iff (!rstN)
      (arriveStb[i] && releaseOut[i]) |=>
        (!releaseOut[i] || (globalFlag != $past(globalFlag))));

    a_r6_only_flip_frees: assert property (@(posedge clk) disable iff (!rstN)
      !releaseOut[i] |=>
        (!releaseOut[i] || (globalFlag != $past(globalFlag))));
  end
endmodule

bind sense_barrier barrier_chk #(.NUM_PARTS(NUM_PARTS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .arriveStb (arriveStb),
  .releaseOut(releaseOut),
  .globalFlag(globalFlag)
);

// File: tb/sense_barrier_tb.sv
module sense_barrier_tb;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [P-1:0] arriveStb = '0;
  logic [P-1:0] releaseOut;
  logic         globalFlag;

  int total = 0;
  int bad = 0;
  logic         mFlag = 1'b0;
  logic [P-1:0] mSense = '0;
  int           mCount = 0;

  sense_barrier #(.NUM_PARTS(P)) u_dut (
    .clk(clk), .rstN(rstN), .arriveStb(arriveStb),
    .releaseOut(releaseOut), .globalFlag(globalFlag)
  );

  always #5 clk = ~clk;

  function automatic logic [P-1:0] expRelease(logic [P-1:0] s, logic f);
    return ~(s ^ {P{f}});
  endfunction

  task automatic modelEdge(logic [P-1:0] arr);
    logic [P-1:0] acc;
    int n;
    acc = arr & expRelease(mSense, mFlag);
    n = $countones(acc);
    mSense = mSense ^ acc;
    if (mCount + n == P) begin
      mCount = 0;
      mFlag = ~mFlag;
    end else begin
      mCount = mCount + n;
    end
  endtask

  task automatic check(string tag, logic [P-1:0] expRel, logic expFlag);
    total++;
    if (releaseOut !== expRel || globalFlag !== expFlag) begin
      bad++;
      $display("FAIL %s: release=%b flag=%b expected release=%b flag=%b",
               tag, releaseOut, globalFlag, expRel, expFlag);
    end
  endtask

  task automatic step(string tag, logic [P-1:0] arr);
    arriveStb = arr;
    @(posedge clk);
    modelEdge(arr);
    @(negedge clk);
    check(tag, expRelease(mSense, mFlag), mFlag);
  endtask

  task automatic finish();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, expected finish");
    finish();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 in reset", '1, 1'b0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 after reset", '1, 1'b0);

    // R2: single arrival makes participant 0 wait
    step("R2 single arrival", 4'b0001);
    check("R2 p0 waiting", 4'b1110, 1'b0);
    // R3: repeated strobe from waiting participant is not counted
    step("R3 repeat while waiting", 4'b0001);
    step("R3 repeat again", 4'b0001);
    step("R6 two more arrive", 4'b0110);
    check("R6 still waiting", 4'b1000, 1'b0);
    step("R5 last arrival", 4'b1000);
    check("R5 all released", 4'b1111, 1'b1);
    // R4 and R7: all at once right after completion
    step("R4 all at once", 4'b1111);
    check("R7 flag back to 0", 4'b1111, 1'b0);
    // R7: immediate re-arrival counted in new episode only
    step("R7 re-arrive p2", 4'b0100);
    check("R7 p2 waits", 4'b1011, 1'b0);
    step("R4 three at once", 4'b1011);
    check("R7 flag 1 again", 4'b1111, 1'b1);

    // R6: random stress against the model
    for (int k = 0; k < 3000; k++) begin
      logic [P-1:0] r;
      r = P'($urandom());
      if ($urandom_range(3) == 0) r = '0;
      step("R6 random", r);
    end
    arriveStb = '0;
    finish();
  end
endmodule